// File: doc/BRIEF.md
# Start-Done Sequential Chain Controller

This block drives a fixed chain of worker units one after another. Each worker has a one-cycle start input and a level idle output. When the controller is idle and sees a start request, it starts worker 0. It then starts each later worker in the cycle where its predecessor reports idle again. After the final worker has finished, the controller raises its own done level.

Progress is kept in a small step register rather than inferred from the workers. Every worker shows idle before the chain begins, so the AND of the idle flags cannot tell "not yet run" apart from "finished". Step 0 means the controller is idle. Step k (1..N) means worker k-1 is next to be launched. Overall done is high only when the step register is 0 and the final worker reports idle. As a result, a second run cannot begin while the final worker is still busy.

Workers must meet one contract. A worker's idle output goes low in the cycle after the cycle in which its start pulse is sampled, and stays low until its work is complete. The chain length NUM_UNITS ranges from 2 to 8.

Top module: `seq_chain_ctrl`

## Requirements
- R1: After reset, done_o is high (with every worker idle) and no bit of unit_go_o is set.
- R2: A start request (go_i high at a clock edge) is accepted only while done_o is high. A request made while the chain runs, or while the final worker is still busy, is ignored and does not start a second run.
- R3: Worker 0 receives its start pulse in the cycle right after the accepting edge.
- R4: Worker k (k ≥ 1) is started in the first cycle, after worker k-1 was started, in which worker k-1 reports idle. It is never started while worker k-1 is busy.
- R5: Each start pulse (unit_go_o bit i starts worker i) lasts exactly one cycle. At most one bit of unit_go_o is high in any cycle. Each worker is started exactly once per run, in index order.
- R6: done_o is never high while any worker is busy. It rises in the cycle after the final worker returns to idle. The total run time is NUM_UNITS cycles plus the sum of the worker latencies, plus one cycle to observe the final idle.
- R7: done_o rises exactly once per accepted run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| go_i | input | 1 | Start request, sampled at each edge |
| done_o | output | 1 | High when idle and the final worker is idle |
| unit_go_o | output | NUM_UNITS | One-cycle start pulse per worker; bit i starts worker i |
| unit_idle_i | input | NUM_UNITS | Idle level from each worker; bit i is worker i |

## Verification
The bound checker tests several rules on every cycle:
- at most one start pulse is high at a time, and each pulse lasts a single cycle;
- an accepted request drops done_o at the next edge and starts worker 0;
- launching the final worker never leaves done_o high.

The bench sweeps worker latencies and checks the timing that only a full run shows. Using latencies from {1,2,3,6} on four workers, it checks:
- the exact start cycle of each worker;
- the absence of starts into a busy predecessor;
- the run length;
- a single done edge per run.

Half of the runs hold go_i high throughout. This shows that requests are ignored mid-chain, and also in the window after the last launch while the final worker is still busy.

// File: rtl/chain_ctrl_pkg.sv
package chain_ctrl_pkg;
  localparam int unsigned MIN_UNITS = 2;
  localparam int unsigned MAX_UNITS = 8;

  // Width of a step register holding 0..n
  function automatic int unsigned step_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction
endpackage

// File: rtl/chain_rst_sync.sv
module chain_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/chain_go_decode.sv
module chain_go_decode #(
  parameter int unsigned NUM_UNITS = 4,
  parameter int unsigned STEP_W    = 3
) (
  input  logic [STEP_W-1:0]    step_i,
  input  logic [NUM_UNITS-1:0] unit_idle_i,
  output logic [NUM_UNITS-1:0] unit_go_o
);
  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_go
    if (i == 0) begin : g_head
      // first worker launches unconditionally in step 1
      assign unit_go_o[i] = (step_i == STEP_W'(1));
    end else begin : g_tail
      // later workers wait for the predecessor to come back idle
      assign unit_go_o[i] = (step_i == STEP_W'(i + 1)) && unit_idle_i[i-1];
    end
  end
endmodule

// File: rtl/chain_step_ctl.sv
module chain_step_ctl #(
  parameter int unsigned NUM_UNITS = 4,
  parameter int unsigned STEP_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              last_idle_i,
  input  logic              any_go_i,
  output logic [STEP_W-1:0] step_o,
  output logic              done_o
);
  localparam logic [STEP_W-1:0] STEP_IDLE = '0;
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NUM_UNITS);

  logic [STEP_W-1:0] step_q, step_nxt;
  logic              step_en;
  logic              done_c;

  always_comb begin
    done_c   = (step_q == STEP_IDLE) && last_idle_i;
    step_nxt = step_q;
    step_en  = 1'b0;
    if (step_q == STEP_IDLE) begin
      if (go_i && done_c) begin
        step_nxt = STEP_W'(1);
        step_en  = 1'b1;
      end
    end else if (any_go_i) begin
      step_en  = 1'b1;
      step_nxt = (step_q == STEP_LAST) ? STEP_IDLE : step_q + STEP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= STEP_IDLE;
    else if (step_en) step_q <= step_nxt;
  end

  assign step_o = step_q;
  assign done_o = done_c;
endmodule

// File: rtl/seq_chain_ctrl.sv
module seq_chain_ctrl #(
  parameter int unsigned NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go_i,
  output logic                 done_o,
  output logic [NUM_UNITS-1:0] unit_go_o,
  input  logic [NUM_UNITS-1:0] unit_idle_i
);
  import chain_ctrl_pkg::*;

  localparam int unsigned STEP_W = step_width(NUM_UNITS);

  logic              rst_n_sync;
  logic [STEP_W-1:0] step;
  logic              any_go;

  chain_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_sync)
  );

  chain_go_decode #(.NUM_UNITS(NUM_UNITS), .STEP_W(STEP_W)) u_dec (
    .step_i      (step),
    .unit_idle_i (unit_idle_i),
    .unit_go_o   (unit_go_o)
  );

  assign any_go = |unit_go_o;

  chain_step_ctl #(.NUM_UNITS(NUM_UNITS), .STEP_W(STEP_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .go_i        (go_i),
    .last_idle_i (unit_idle_i[NUM_UNITS-1]),
    .any_go_i    (any_go),
    .step_o      (step),
    .done_o      (done_o)
  );
endmodule

// File: rtl/chain_ctrl_chk.sv
module chain_ctrl_chk #(
  parameter int unsigned NUM_UNITS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 go_i,
  input logic                 done_o,
  input logic [NUM_UNITS-1:0] unit_go_o,
  input logic [NUM_UNITS-1:0] unit_idle_i
);
  // R5: never two workers launched together
  p_onehot_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_go_o));

  // R5: a launch bit never stays high into the next cycle
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_go_o != '0) |=> ((unit_go_o & $past(unit_go_o)) == '0));

  // R2: an accepted request leaves the done state
  p_accept_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && done_o) |=> !done_o);

  // R3: worker 0 launched right after acceptance
  p_first_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && done_o) |=> unit_go_o[0]);

  // R6: done cannot be high just after the final worker was launched
  p_last_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unit_go_o[NUM_UNITS-1] |=> !done_o);
endmodule

bind seq_chain_ctrl chain_ctrl_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .go_i        (go_i),
  .done_o      (done_o),
  .unit_go_o   (unit_go_o),
  .unit_idle_i (unit_idle_i)
);

// File: tb/seq_chain_ctrl_test.sv
`timescale 1ns/1ps
module seq_chain_ctrl_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         go_i = 1'b0;
  logic         done_o;
  logic [N-1:0] unit_go_o;
  logic [N-1:0] unit_idle_i;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  int lat [N];
  logic [3:0] cnt [N];

  // monitor state
  int acc_cnt, acc_cyc, rises, rise_cyc, overlap, bad_done;
  int pulses [N];
  int start_cyc [N];
  logic done_prev = 1'b1;

  always #2.5 clk = ~clk;

  seq_chain_ctrl #(.NUM_UNITS(N)) uut (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .done_o(done_o),
    .unit_go_o(unit_go_o), .unit_idle_i(unit_idle_i)
  );

  // worker models: idle drops the cycle after launch, for lat cycles
  for (genvar i = 0; i < N; i++) begin : g_work
    always @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt[i] <= '0;
      else if (unit_go_o[i])  cnt[i] <= 4'(lat[i]);
      else if (cnt[i] != 0)   cnt[i] <= cnt[i] - 4'd1;
    end
    assign unit_idle_i[i] = (cnt[i] == 0);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (go_i && done_o) begin acc_cnt++; acc_cyc = cyc; end
    for (int i = 0; i < N; i++) begin
      if (unit_go_o[i]) begin
        pulses[i]++;
        start_cyc[i] = cyc;
        if (i > 0 && cnt[i-1] != 0) overlap++;
      end
    end
    if (done_o && !done_prev) begin rises++; rise_cyc = cyc; end
    done_prev = done_o;
    if (done_o && (unit_idle_i != '1)) bad_done++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_chain(input bit stress);
    int exp_start [N];
    int exp_rise;
    int guard;
    acc_cnt = 0; rises = 0; overlap = 0; bad_done = 0;
    for (int i = 0; i < N; i++) begin pulses[i] = 0; start_cyc[i] = -1; end
    go_i = 1'b1;
    @(negedge clk);
    if (!stress) go_i = 1'b0;
    guard = 0;
    while (!done_o && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    go_i = 1'b0;
    repeat (3) @(negedge clk);
    exp_start[0] = acc_cyc + 1;
    for (int k = 1; k < N; k++) exp_start[k] = exp_start[k-1] + lat[k-1] + 1;
    exp_rise = exp_start[N-1] + lat[N-1] + 1;
    check(acc_cnt == 1, "R2 accepted requests", acc_cnt, 1);
    check(start_cyc[0] == exp_start[0], "R3 worker0 start cycle", start_cyc[0], exp_start[0]);
    for (int k = 1; k < N; k++)
      check(start_cyc[k] == exp_start[k], "R4 worker start cycle", start_cyc[k], exp_start[k]);
    check(overlap == 0, "R4 start into busy predecessor", overlap, 0);
    for (int k = 0; k < N; k++)
      check(pulses[k] == 1, "R5 pulse count", pulses[k], 1);
    check(bad_done == 0, "R6 done while worker busy", bad_done, 0);
    check(rise_cyc == exp_rise, "R6 done rise cycle", rise_cyc, exp_rise);
    check(rises == 1, "R7 done edges per run", rises, 1);
  endtask

  function automatic int lat_of(input int d);
    return (d == 0) ? 1 : (d == 1) ? 2 : (d == 2) ? 3 : 6;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < N; i++) lat[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(done_o == 1'b1, "R1 done after reset", int'(done_o), 1);
    check(unit_go_o == '0, "R1 no launch after reset", int'(unit_go_o), 0);
    for (int code = 0; code < 256; code++) begin
      for (int i = 0; i < N; i++) lat[i] = lat_of((code >> (2*i)) & 3);
      run_chain(code[0]);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule